// File: doc/BRIEF.md
# Eight-pin GPIO port with guarded alternate-function select

This block is an eight-pin general-purpose I/O port that sits on a simple register bus. The bus has a byte offset within a 4 KB window, a write strobe, 32-bit write data and a combinational 32-bit read path. Each pin is set as an input or an output. Input levels pass through a two-flop synchronizer and are copied into the port's data register. Output pins are driven from that register. Software reaches the data register through an address-masked window: the offset bits select which pins a read shows and which pins a write may touch.

The synchronized inputs feed a per-pin interrupt detector. Each pin can detect a level, any edge, or one chosen edge, and the detector sets sticky raw status bits. Software clears those bits by writing ones, and an enable mask reduces the bits to one interrupt line. The pad-control registers are plain storage. The alternate-function select register is guarded by a commit mask. Software can change that mask only after it writes a 32-bit key to the lock register. A table of twelve read-only identification bytes occupies the top of the window.

Top module: `gpio_port8`

## Requirements
- R1: A read at any offset below 0x400 returns the data register ANDed with byte-offset bits [9:2], with zeros in bits 31:8.
- R2: A write at any offset below 0x400 changes only the data bits that are both selected by byte-offset bits [9:2] and set in the direction register (1 = output). `pin_out` equals data AND direction, and `pin_oe` equals direction.
- R3: Each data bit whose direction is 0 takes the level of `pin_in` through two synchronizer flops. A change of `pin_in` before clock edge k therefore appears in the data register after edge k+2.
- R4: Direction (0x400), sense (0x404), both-edges (0x408), event (0x40C), mask (0x410) and the eight pad registers (0x500 to 0x51C, one per word) are 8-bit read/write registers that reset to 0.
- R5: Writing 0x0ACCE551 to 0x520 unlocks the port, and any other value written there locks it. A read of 0x520 returns 1 when locked and 0 when unlocked. The port is locked after reset.
- R6: The commit register (0x524) resets to 0xFF and takes a write only while the port is unlocked.
- R7: A write to the alternate-function select (0x420, reset 0) changes only the bits that are set in the commit register.
- R8: A raw status bit (read at 0x414) is set when its pin's detector fires, on the synchronized input. The detector modes are: sense=1 selects level, firing while the input equals the event bit; otherwise both-edges=1 selects any edge; otherwise event=1 selects a rising edge and event=0 a falling edge. Writing ones to 0x41C clears raw bits, but a detection in the same cycle wins over the clear.
- R9: A read of 0x418 returns raw status AND mask, and `irq` is high exactly when that value is nonzero.
- R10: Word k (k = 0 to 11) of offsets 0xFD0 to 0xFFC reads 0x00, 0x00, 0x00, 0x00, 0x61, 0x00, 0x18, 0x01, 0x0D, 0xF0, 0x05 and 0xB1 in that order. Every other unmapped offset reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 12 | Byte offset in the register window; bits 1:0 are ignored |
| wr_en | input | 1 | Write strobe for the current offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current offset (combinational) |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Output pin levels |
| pin_oe | output | 8 | Output enable per pin |
| irq | output | 1 | OR of the enabled raw status bits |

## Verification
The bench writes data through partial address masks while the pins are split between inputs and outputs. A design that ignored the mask, or that let writes reach input pins, would show wrong `pin_out` values or wrong data readback. It writes the commit register while the port is locked, then writes the alternate-function select after narrowing the commit mask. A broken guard would change either register. It drives one pin in each detector mode through rising and falling transitions. It clears a level-sensitive pin while its level still holds. A wrong edge polarity, a missing synchronizer stage, or a clear that beats a fresh detection each makes the raw status, the masked status or `irq` differ from the cycle model. The identification words are read in order and compared.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter logic [31:0] UNLOCK_KEY = 32'h0ACC_E551
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [7:0]  pin_in,
  output logic [7:0]  pin_out,
  output logic [7:0]  pin_oe,
  output logic        irq
);
  localparam int NPIN = 8;

  logic [11:0] wa;
  logic [7:0]  data_q, dir_q, sense_q, both_q, evt_q, ena_q, raw_q, alt_q, commit_q;
  logic [7:0]  pad_q [8];
  logic [7:0]  s1_q, s2_q, s3_q, det, dmask, clr;
  logic        locked_q;
  logic        data_wr;

  assign wa      = {addr[11:2], 2'b00};
  assign data_wr = wr_en && (wa < 12'h400);
  assign dmask   = data_wr ? (addr[9:2] & dir_q) : 8'h00;
  assign clr     = (wr_en && wa == 12'h41C) ? wr_data[7:0] : 8'h00;

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (sense_q[i])     det[i] = ~(s2_q[i] ^ evt_q[i]);
      else if (both_q[i]) det[i] = s2_q[i] ^ s3_q[i];
      else if (evt_q[i])  det[i] = s2_q[i] & ~s3_q[i];
      else                det[i] = ~s2_q[i] & s3_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1_q, s2_q, s3_q} <= '0;
      data_q <= '0;
      raw_q  <= '0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      data_q <= (dir_q & ((data_q & ~dmask) | (wr_data[7:0] & dmask))) | (~dir_q & s2_q);
      raw_q  <= (raw_q & ~clr) | det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; sense_q <= '0; both_q <= '0; evt_q <= '0; ena_q <= '0;
      alt_q <= '0; commit_q <= 8'hFF; locked_q <= 1'b1;
      for (int i = 0; i < 8; i++) pad_q[i] <= '0;
    end else if (wr_en) begin
      case (wa)
        12'h400: dir_q   <= wr_data[7:0];
        12'h404: sense_q <= wr_data[7:0];
        12'h408: both_q  <= wr_data[7:0];
        12'h40C: evt_q   <= wr_data[7:0];
        12'h410: ena_q   <= wr_data[7:0];
        12'h420: alt_q   <= (alt_q & ~commit_q) | (wr_data[7:0] & commit_q);
        12'h520: locked_q <= (wr_data != UNLOCK_KEY);
        12'h524: if (!locked_q) commit_q <= wr_data[7:0];
        default: if (wa[11:5] == 7'h28) pad_q[wa[4:2]] <= wr_data[7:0];
      endcase
    end
  end

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd4:  return 8'h61;
      4'd6:  return 8'h18;
      4'd7:  return 8'h01;
      4'd8:  return 8'h0D;
      4'd9:  return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  logic [11:0] id_off;
  assign id_off = wa - 12'hFD0;

  always_comb begin
    rd_data = '0;
    if (wa < 12'h400) rd_data[7:0] = data_q & addr[9:2];
    else if (wa >= 12'hFD0) rd_data[7:0] = id_byte(id_off[5:2]);
    else if (wa[11:5] == 7'h28) rd_data[7:0] = pad_q[wa[4:2]];
    else begin
      case (wa)
        12'h400: rd_data[7:0] = dir_q;
        12'h404: rd_data[7:0] = sense_q;
        12'h408: rd_data[7:0] = both_q;
        12'h40C: rd_data[7:0] = evt_q;
        12'h410: rd_data[7:0] = ena_q;
        12'h414: rd_data[7:0] = raw_q;
        12'h418: rd_data[7:0] = raw_q & ena_q;
        12'h420: rd_data[7:0] = alt_q;
        12'h520: rd_data[0]   = locked_q;
        12'h524: rd_data[7:0] = commit_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign pin_out = data_q & dir_q;
  assign pin_oe  = dir_q;
  assign irq     = |(raw_q & ena_q);

  p_out_bits_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~($past(addr[9:2]) & {8{$past(data_wr)}})) == 8'h00));

  p_commit_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(commit_q));

  p_alt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == 8'h00));

  p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wa == 12'h41C) |=> ((raw_q & $past(wr_data[7:0]) & ~$past(det)) == 8'h00));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[7:0] != 8'h00 || wa != 12'h418));
endmodule

// File: tb/gpio_port8_bench.sv
`timescale 1ns/1ps
module gpio_port8_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  pin_in = '0;
  logic [31:0] rd_data;
  logic [7:0]  pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  string tag = "R4";

  always #10 clk = ~clk;

  gpio_port8 u_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  logic [7:0] m_data, m_dir, m_sense, m_both, m_evt, m_ena, m_raw, m_alt, m_commit;
  logic [7:0] m_pad [8];
  int         m_locked;
  logic [7:0] sync_q [$];
  logic [7:0] id_tab [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                              8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(logic [11:0] a);
    int w = {a[11:2], 2'b00};
    if (w < 'h400) return {24'h0, m_data & a[9:2]};
    if (w >= 'hFD0) return {24'h0, id_tab[(w - 'hFD0) / 4]};
    if (w >= 'h500 && w < 'h520) return {24'h0, m_pad[(w - 'h500) / 4]};
    case (w)
      'h400: return {24'h0, m_dir};
      'h404: return {24'h0, m_sense};
      'h408: return {24'h0, m_both};
      'h40C: return {24'h0, m_evt};
      'h410: return {24'h0, m_ena};
      'h414: return {24'h0, m_raw};
      'h418: return {24'h0, m_raw & m_ena};
      'h420: return {24'h0, m_alt};
      'h520: return m_locked;
      'h524: return {24'h0, m_commit};
      default: return 0;
    endcase
  endfunction

  task automatic model_clock();
    logic [7:0] s2, s3, det, nd;
    int w;
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_sense = 0; m_both = 0; m_evt = 0; m_ena = 0;
      m_raw = 0; m_alt = 0; m_commit = 8'hFF; m_locked = 1;
      foreach (m_pad[i]) m_pad[i] = 0;
      sync_q = '{8'h00, 8'h00, 8'h00};
      return;
    end
    s2 = sync_q[1]; s3 = sync_q[2];
    w = {addr[11:2], 2'b00};
    for (int i = 0; i < 8; i++) begin
      if (m_sense[i]) det[i] = (s2[i] == m_evt[i]);
      else if (m_both[i]) det[i] = (s2[i] != s3[i]);
      else if (m_evt[i]) det[i] = s2[i] && !s3[i];
      else det[i] = !s2[i] && s3[i];
      if (!m_dir[i]) nd[i] = s2[i];
      else if (wr_en && w < 'h400 && addr[i+2]) nd[i] = wr_data[i];
      else nd[i] = m_data[i];
    end
    m_data = nd;
    if (wr_en && w == 'h41C) m_raw = m_raw & ~wr_data[7:0];
    m_raw = m_raw | det;
    if (wr_en) begin
      if (w >= 'h500 && w < 'h520) m_pad[(w - 'h500) / 4] = wr_data[7:0];
      case (w)
        'h400: m_dir = wr_data[7:0];
        'h404: m_sense = wr_data[7:0];
        'h408: m_both = wr_data[7:0];
        'h40C: m_evt = wr_data[7:0];
        'h410: m_ena = wr_data[7:0];
        'h420: for (int i = 0; i < 8; i++) if (m_commit[i]) m_alt[i] = wr_data[i];
        'h520: m_locked = (wr_data == 32'h0ACCE551) ? 0 : 1;
        'h524: if (m_locked == 0) m_commit = wr_data[7:0];
        default: ;
      endcase
    end
    sync_q.push_front(pin_in);
    void'(sync_q.pop_back());
  endtask

  task automatic step();
    @(posedge clk);
    model_clock();
    #5;
    chk({tag, " rd_data"}, rd_data, mrd(addr));
    chk({tag, " pin_out"}, {24'h0, pin_out}, {24'h0, m_data & m_dir});
    chk({tag, " pin_oe"}, {24'h0, pin_oe}, {24'h0, m_dir});
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_raw & m_ena)});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string t, logic [11:0] a, logic [31:0] exp);
    addr = a; wr_en = 1'b0;
    #1;
    chk(t, rd_data, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    tag = "R5";
    rdchk("R5 locked after reset", 12'h520, 32'h1);
    rdchk("R6 commit reset", 12'h524, 32'hFF);
    rdchk("R4 dir reset", 12'h400, 32'h0);
    rdchk("R7 alt reset", 12'h420, 32'h0);

    tag = "R4";
    wr(12'h404, 32'h12); wr(12'h408, 32'h34); wr(12'h40C, 32'h56); wr(12'h410, 32'h78);
    for (int i = 0; i < 8; i++) wr(12'h500 + 12'(4 * i), 32'(8'h90 + i));
    rdchk("R4 sense", 12'h404, 32'h12);
    rdchk("R4 event", 12'h40C, 32'h56);
    for (int i = 0; i < 8; i++) rdchk("R4 pad", 12'h500 + 12'(4 * i), 32'(8'h90 + i));
    wr(12'h404, 0); wr(12'h408, 0); wr(12'h40C, 0); wr(12'h410, 0);

    tag = "R2";
    wr(12'h400, 32'hF0);
    wr(12'h3FC, 32'hAA);
    idle(1);
    chk("R2 masked write all", {24'h0, pin_out}, 32'hA0);
    wr(12'h0C0, 32'h00);
    idle(1);
    chk("R2 partial mask", {24'h0, pin_out}, 32'h80);
    wr(12'h03C, 32'hFF);
    idle(1);
    chk("R2 input pins untouched", {24'h0, pin_out}, 32'h80);

    tag = "R3";
    pin_in = 8'h05;
    step(); step();
    rdchk("R3 not yet visible", 12'h3FC, 32'h80);
    step();
    rdchk("R3 synced input", 12'h3FC, 32'h85);
    tag = "R1";
    rdchk("R1 read mask", 12'h03C, 32'h05);
    rdchk("R1 read mask high", 12'h200, 32'h80);

    tag = "R7";
    wr(12'h420, 32'hFF);
    rdchk("R7 full commit", 12'h420, 32'hFF);
    tag = "R6";
    wr(12'h524, 32'h0F);
    rdchk("R6 locked commit", 12'h524, 32'hFF);
    tag = "R5";
    wr(12'h520, 32'h0ACCE551);
    rdchk("R5 unlocked", 12'h520, 32'h0);
    wr(12'h524, 32'h0F);
    rdchk("R6 unlocked commit", 12'h524, 32'h0F);
    wr(12'h520, 32'h0ACCE550);
    rdchk("R5 relocked", 12'h520, 32'h1);
    tag = "R7";
    wr(12'h420, 32'h00);
    rdchk("R7 gated alt", 12'h420, 32'hF0);

    tag = "R8";
    wr(12'h400, 32'h00);
    wr(12'h40C, 32'h09);
    wr(12'h408, 32'h04);
    wr(12'h404, 32'h08);
    idle(4);
    wr(12'h41C, 32'hFF);
    idle(2);
    rdchk("R8 cleared", 12'h414, 32'h00);
    pin_in = 8'h0A;
    idle(5);
    rdchk("R8 both edge and level", 12'h414, 32'h0C);
    pin_in = 8'h09;
    idle(5);
    rdchk("R8 rise and fall", 12'h414, 32'h0F);
    wr(12'h41C, 32'h0F);
    idle(1);
    rdchk("R8 level wins clear", 12'h414, 32'h08);
    tag = "R9";
    wr(12'h410, 32'h04);
    rdchk("R9 masked off", 12'h418, 32'h00);
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    wr(12'h410, 32'h08);
    rdchk("R9 masked on", 12'h418, 32'h08);
    chk("R9 irq high", {31'h0, irq}, 32'h1);

    tag = "R10";
    for (int k = 0; k < 12; k++) rdchk("R10 id", 12'hFD0 + 12'(4 * k), {24'h0, id_tab[k]});
    wr(12'h600, 32'hFF);
    rdchk("R10 unmapped", 12'h600, 32'h0);
    rdchk("R10 write ignored", 12'h410, 32'h08);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule